// File: doc/BRIEF.md
# Low-Power Entry Debug Handshake

This block holds off a device's entry into sleep or stop mode until an attached debug tool has seen the entry coming and agreed to it. It sits between the power controller, which raises a sleep or stop request, and the tool. The tool reaches the block through a 32-bit register with a write strobe and a continuous read path. When the low-power debug enable bit is clear, requests pass straight through. Each one is granted one cycle later.

When the enable bit is set, a request raises a per-mode pending flag in the register. The grant is withheld until the tool acknowledges by writing 0 to that flag. Sleep and stop each have their own flag and their own sequencer. A request that is withdrawn while pending is dropped without a grant. Every grant is a single-cycle pulse, and the power controller must lower its request before the same mode can be requested again.

Top module: `lpdbg_handshake`

## Requirements
- R1: After a synchronous active-low reset the register reads all zeros and both grant outputs are low.
- R2: Register fields, in vector indices where index 31 is the most significant bit, are as follows. The event port enable is at index 25 and also drives `evt_port_en`. The low-power debug enable is at index 15. The sleep pending flag is at index 9 and the stop pending flag is at index 8. Every other bit reads 0 and ignores writes.
- R3: With the debug enable at 0, a request that rises is granted in the following cycle and no pending flag is set.
- R4: With the debug enable at 1, a request that rises sets its mode's pending flag in the following cycle. No grant is given while the flag reads 1.
- R5: Writing 1 to a pending flag has no effect: a clear flag stays clear and a set flag stays set.
- R6: Writing 0 to a set pending flag clears it at that clock edge, and the mode's grant is high in the cycle after the write.
- R7: The sleep and stop flags and grants are independent; acknowledging one leaves the other pending.
- R8: If a request sets a flag in the same cycle that a register write puts 0 in that flag, the flag ends up set.
- R9: A grant lasts exactly one cycle. While the request stays high after a grant, no flag is set and no further grant is given. A new request cycle starts only after the request has been low for at least one cycle.
- R10: If a request falls while its flag is pending, the flag clears in the next cycle and no grant is given.
- R11: If the debug enable is cleared while a flag is pending, the flag clears and the grant pulses in the cycle after the enable first reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe from the debug tool |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| sleep_req | input | 1 | Sleep-entry request from the power controller |
| stop_req | input | 1 | Stop-entry request from the power controller |
| sleep_grant | output | 1 | One-cycle sleep-entry grant |
| stop_grant | output | 1 | One-cycle stop-entry grant |
| evt_port_en | output | 1 | Event port enable bit |

## Verification
The bench drives a request and a flag-clearing write into the same cycle. A design that lets the clear win would lose that request and never set the flag. It writes ones to the pending flags, which a design that let the tool set them would show as a flag with no request behind it. The bench holds requests high after their grant to catch a repeated grant or a re-armed flag. It also withdraws a pending request and turns the enable off under a pending flag, which expose a stray grant in the first case and a device stuck forever in the second. An all-ones write checks that the reserved bits stay zero and that ones written to the flags do not set them.

// File: rtl/lpdbg_pkg.sv
// Shared constants and types for the low-power entry debug handshake.
// Field positions are vector indices with index REG_W-1 as the MSB.
package lpdbg_pkg;
    localparam int REG_W       = 32;
    localparam int NUM_MODES   = 2;
    localparam int MODE_SLEEP  = 0;
    localparam int MODE_STOP   = 1;

    // Positions given in MSB-first numbering, converted to vector indices.
    localparam int EVT_EN_NUM  = 6;
    localparam int DBG_EN_NUM  = 16;
    localparam int SLEEP_NUM   = 22;
    localparam int STOP_NUM    = 23;

    localparam int EVT_EN_POS  = REG_W - 1 - EVT_EN_NUM;
    localparam int DBG_EN_POS  = REG_W - 1 - DBG_EN_NUM;
    localparam int SLEEP_POS   = REG_W - 1 - SLEEP_NUM;
    localparam int STOP_POS    = REG_W - 1 - STOP_NUM;

    // Mask of the bits that hold state; everything else reads zero.
    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'(1) << EVT_EN_POS) | (REG_W'(1) << DBG_EN_POS) |
        (REG_W'(1) << SLEEP_POS)  | (REG_W'(1) << STOP_POS);

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_PEND = 2'd1,
        CH_HOLD = 2'd2
    } chan_state_t;

    // Vector index of a mode's pending flag.
    function automatic int flag_pos(input int mode);
        return (mode == MODE_SLEEP) ? SLEEP_POS : STOP_POS;
    endfunction
endpackage

// File: rtl/lpdbg_cfg_reg.sv
// Tool-writable configuration bits: event port enable and low-power
// debug enable. It also decodes which pending flags a write acknowledges
// (a written 0 clears, a written 1 is ignored).
// Assumes the write strobe is synchronous to clk.
module lpdbg_cfg_reg
    import lpdbg_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int MODES = NUM_MODES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    output logic             evt_en,
    output logic             dbg_en,
    output logic [MODES-1:0] ack_clr
);
    // Store the two enable bits on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_en <= 1'b0;
            dbg_en <= 1'b0;
        end else if (wr_en) begin
            evt_en <= wr_data[EVT_EN_POS];
            dbg_en <= wr_data[DBG_EN_POS];
        end
    end

    // One acknowledge per mode when the write carries a 0 in its flag.
    for (genvar m = 0; m < MODES; m++) begin : g_ack
        localparam int POS = flag_pos(m);
        always_comb ack_clr[m] = wr_en && !wr_data[POS];
    end
endmodule

// File: rtl/lpdbg_chan.sv
// Per-mode entry sequencer. It sets the pending flag on a new request
// when debug is enabled, waits for the acknowledge, then pulses the grant
// and holds until the request drops. When debug is disabled the grant
// follows the request directly.
// Assumes req stays high until granted or withdrawn.
module lpdbg_chan
    import lpdbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic dbg_en,
    input  logic ack_clr,
    output logic pend_flag,
    output logic grant
);
    chan_state_t state;

    // Sequencer: flag set wins over a same-cycle acknowledge in IDLE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CH_IDLE;
            pend_flag <= 1'b0;
            grant     <= 1'b0;
        end else begin
            grant <= 1'b0;
            unique case (state)
                CH_IDLE: begin
                    if (req) begin
                        if (dbg_en) begin
                            pend_flag <= 1'b1;
                            state     <= CH_PEND;
                        end else begin
                            grant <= 1'b1;
                            state <= CH_HOLD;
                        end
                    end
                end
                CH_PEND: begin
                    if (!req) begin
                        pend_flag <= 1'b0;
                        state     <= CH_IDLE;
                    end else if (ack_clr || !dbg_en) begin
                        pend_flag <= 1'b0;
                        grant     <= 1'b1;
                        state     <= CH_HOLD;
                    end
                end
                CH_HOLD: begin
                    if (!req) state <= CH_IDLE;
                end
                default: begin
                    pend_flag <= 1'b0;
                    state     <= CH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/lpdbg_handshake.sv
// Top of the low-power entry debug handshake: one configuration register
// plus one sequencer per low-power mode, with readback assembly.
// Assumes all inputs are synchronous to clk.
module lpdbg_handshake
    import lpdbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             sleep_req,
    input  logic             stop_req,
    output logic             sleep_grant,
    output logic             stop_grant,
    output logic             evt_port_en
);
    logic                 dbg_en;
    logic [NUM_MODES-1:0] ack_clr;
    logic [NUM_MODES-1:0] req_v;
    logic [NUM_MODES-1:0] flag_v;
    logic [NUM_MODES-1:0] grant_v;

    lpdbg_cfg_reg #(.W(REG_W), .MODES(NUM_MODES)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .evt_en  (evt_port_en),
        .dbg_en  (dbg_en),
        .ack_clr (ack_clr)
    );

    // Gather the mode requests into a vector.
    always_comb begin
        req_v[MODE_SLEEP] = sleep_req;
        req_v[MODE_STOP]  = stop_req;
    end

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_chan
        lpdbg_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_v[m]),
            .dbg_en    (dbg_en),
            .ack_clr   (ack_clr[m]),
            .pend_flag (flag_v[m]),
            .grant     (grant_v[m])
        );
    end

    // Fan the grants out to their ports.
    always_comb begin
        sleep_grant = grant_v[MODE_SLEEP];
        stop_grant  = grant_v[MODE_STOP];
    end

    // Assemble readback; unlisted bits stay zero.
    always_comb begin
        reg_rd_data             = '0;
        reg_rd_data[EVT_EN_POS] = evt_port_en;
        reg_rd_data[DBG_EN_POS] = dbg_en;
        reg_rd_data[SLEEP_POS]  = flag_v[MODE_SLEEP];
        reg_rd_data[STOP_POS]   = flag_v[MODE_STOP];
    end
endmodule

// File: rtl/lpdbg_handshake_chk.sv
// Protocol checker for lpdbg_handshake, attached through bind.
module lpdbg_handshake_chk
    import lpdbg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] reg_rd_data,
    input logic             sleep_req,
    input logic             stop_req,
    input logic             sleep_grant,
    input logic             stop_grant
);
    logic en_q, sflag, tflag;
    always_comb begin
        en_q  = reg_rd_data[DBG_EN_POS];
        sflag = reg_rd_data[SLEEP_POS];
        tflag = reg_rd_data[STOP_POS];
    end

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data & ~LIVE_MASK) == '0);

    assert_bypass_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleep_req) && !en_q) |=> sleep_grant);

    assert_bypass_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stop_req) && !en_q) |=> stop_grant);

    assert_sleep_set_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sflag) |-> ($past(sleep_req) && $past(en_q)));

    assert_stop_set_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tflag) |-> ($past(stop_req) && $past(en_q)));

    assert_no_grant_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_grant && sflag) && !(stop_grant && tflag));

    assert_sleep_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_grant |=> !sleep_grant);

    assert_stop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_grant |=> !stop_grant);

    assert_sleep_withdraw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sflag && !sleep_req) |=> (!sflag && !sleep_grant));

    assert_stop_withdraw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tflag && !stop_req) |=> (!tflag && !stop_grant));
endmodule

bind lpdbg_handshake lpdbg_handshake_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd_data (reg_rd_data),
    .sleep_req   (sleep_req),
    .stop_req    (stop_req),
    .sleep_grant (sleep_grant),
    .stop_grant  (stop_grant)
);

// File: tb/lpdbg_handshake_test.sv
module lpdbg_handshake_test;
    localparam logic [31:0] EN  = 32'h0000_8000;
    localparam logic [31:0] EVT = 32'h0200_0000;
    localparam logic [31:0] SLP = 32'h0000_0200;
    localparam logic [31:0] STP = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic        sleep_req, stop_req, sleep_grant, stop_grant, evt_port_en;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    lpdbg_handshake uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .sleep_req(sleep_req), .stop_req(stop_req),
        .sleep_grant(sleep_grant), .stop_grant(stop_grant), .evt_port_en(evt_port_en)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        tick();
        reg_wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rd", reg_rd_data, 32'h0);
        check("R1 grants", {30'h0, sleep_grant, stop_grant}, 32'h0);
    endtask

    task automatic t_bypass();
        sleep_req = 1'b1; tick();
        check("R3 sleep grant", 32'(sleep_grant), 32'h1);
        check("R3 no flag", reg_rd_data, 32'h0);
        tick();
        check("R9 pulse ends", 32'(sleep_grant), 32'h0);
        tick();
        check("R9 no regrant while held", 32'(sleep_grant), 32'h0);
        sleep_req = 1'b0; tick();
        stop_req = 1'b1; tick();
        check("R3 stop grant", 32'(stop_grant), 32'h1);
        stop_req = 1'b0; tick(); tick();
    endtask

    task automatic t_handshake();
        wr(EN);
        check("R2 enable readback", reg_rd_data, EN);
        sleep_req = 1'b1; tick();
        check("R4 flag set", reg_rd_data, EN | SLP);
        check("R4 no grant", 32'(sleep_grant), 32'h0);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R4 held off", 32'(sleep_grant), 32'h0);
        end
        wr(EN | SLP | STP);
        check("R5 write one ignored", reg_rd_data, EN | SLP);
        check("R5 no grant", 32'(sleep_grant), 32'h0);
        wr(EN | STP);
        check("R6 grant after ack", 32'(sleep_grant), 32'h1);
        check("R6 flag cleared", reg_rd_data, EN);
        tick();
        check("R9 pulse ends", 32'(sleep_grant), 32'h0);
        check("R9 no rearm while held", reg_rd_data, EN);
        sleep_req = 1'b0; tick();
    endtask

    task automatic t_independent();
        stop_req = 1'b1; tick();
        check("R7 stop pending only", reg_rd_data, EN | STP);
        wr(EN | STP);
        check("R7 stop still pending", reg_rd_data, EN | STP);
        check("R7 no stop grant", 32'(stop_grant), 32'h0);
        wr(EN | SLP);
        check("R7 stop grant", 32'(stop_grant), 32'h1);
        check("R7 sleep untouched", 32'(sleep_grant), 32'h0);
        stop_req = 1'b0; tick();
    endtask

    task automatic t_set_wins_and_withdraw();
        sleep_req = 1'b1;
        wr(EN);
        check("R8 set beats clear", reg_rd_data, EN | SLP);
        sleep_req = 1'b0; tick();
        check("R10 flag dropped", reg_rd_data, EN);
        check("R10 no grant", 32'(sleep_grant), 32'h0);
        tick();
        check("R10 still no grant", 32'(sleep_grant), 32'h0);
    endtask

    task automatic t_disable_pending();
        sleep_req = 1'b1; tick();
        check("R11 pending", reg_rd_data, EN | SLP);
        wr(SLP | STP);
        check("R11 enable off, flag kept", reg_rd_data, SLP);
        tick();
        check("R11 released grant", 32'(sleep_grant), 32'h1);
        check("R11 flag cleared", reg_rd_data, 32'h0);
        sleep_req = 1'b0; tick();
    endtask

    task automatic t_reserved();
        wr(32'hFFFF_FFFF);
        check("R2 reserved zero", reg_rd_data, EVT | EN);
        check("R2 evt port", 32'(evt_port_en), 32'h1);
        wr(32'h0);
        check("R2 cleared", reg_rd_data, 32'h0);
        check("R2 evt port off", 32'(evt_port_en), 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_data = '0;
        sleep_req = 1'b0; stop_req = 1'b0;
        tick(); tick();
        rst_n = 1'b1; tick();
        t_reset();
        t_bypass();
        t_handshake();
        t_independent();
        t_set_wins_and_withdraw();
        t_disable_pending();
        t_reserved();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule